// File: doc/BRIEF.md
# Move-Triggered Arithmetic Unit with Bus Sockets

This block is an arithmetic/logic unit that sits on a set of parallel move buses. It receives its work only through data moves. Each bus carries three things in a cycle: a data word, a socket identifier and an opcode field. The unit has three sockets, and each is recognised by its own identifier.

- A move addressed to the **operand socket** only loads the operand register.
- A move addressed to the **trigger socket** supplies the second operand together with the opcode. That move is what starts the operation.
- A bus that addresses the **result socket** has the result register placed on it during the same cycle.

The unit is fully pipelined and has a fixed latency of one or two cycles, chosen by a parameter. A new trigger may arrive in every cycle. The move buses work independently, so the unit can receive an operand, receive a trigger and deliver a result on different buses in one cycle.

Other units may also drive the same buses. Each bus therefore has an external driver-enable input, which collects the enables of the other result sockets on that bus. The unit raises a per-bus conflict flag when its own result socket and some other driver enable the same bus in the same cycle.

Top module: `ttfu_socket_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, no bus is driven (all enables 0) and the result register reads 0.
- R2: A move whose socket ID equals OPND_SID (default 1) replaces the stored operand and never starts an operation; the readable result stays unchanged.
- R3: A move whose socket ID equals TRIG_SID (default 2) starts an operation on stored operand A and trigger data B. The opcode is 3 bits: 0 gives A+B, 1 gives A-B (both modulo 2^DW), 2 gives A&B, 3 gives A|B, 4 gives A^B, 5 gives 1 if A<B unsigned and 0 otherwise, and 6 and 7 give 0.
- R4: The result of a trigger move in cycle k is readable from cycle k+LATENCY (default 2). Before that cycle the previous result is read, and the result is held until a later operation completes.
- R5: Triggers may arrive in consecutive cycles; each result appears exactly LATENCY cycles after its trigger, in trigger order.
- R6: When an operand move and a trigger move occur in the same cycle, the operation uses the newly moved operand, and that operand also stays stored for later triggers.
- R7: When several buses carry the same socket ID in one cycle, the move on the lowest-numbered bus is taken and the others are ignored.
- R8: In a cycle where a bus carries socket ID RES_SID (default 3), the unit drives the result register onto that bus and sets that bus's enable. Every bus carrying another ID gets data 0 with its enable low. Several buses may read the result at once.
- R9: The conflict flag of a bus is 1 exactly when the unit drives that bus and the external driver-enable of that bus is also 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sid_i | input | NUM_BUS*SID_W | Socket ID on each bus; bus b occupies bits [b*SID_W +: SID_W] |
| bus_data_i | input | NUM_BUS*DW | Data word on each bus |
| bus_op_i | input | NUM_BUS*3 | Opcode field on each bus, used only by trigger moves |
| ext_drv_i | input | NUM_BUS | Combined driver enables of other units, one bit per bus |
| bus_data_o | output | NUM_BUS*DW | Result data driven onto each bus (0 when not driving) |
| bus_drv_o | output | NUM_BUS | Result-socket driver enable per bus |
| conflict_o | output | NUM_BUS | Per-bus flag for more than one enabled driver |

## Verification
The assertions assume that all bus inputs are synchronous to the clock, hold steady across each rising edge, and are free of X after reset. The hold-and-latency property assumes that socket IDs are compared at full width, so only an exact TRIG_SID value counts as a trigger. The stimulus changes the buses only on falling edges and puts ID 0, which matches no socket, on every bus that is idle. It applies the reset-release check before it sends any move.

// File: rtl/ttfu_pkg.sv
package ttfu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_CMP = 3'd5
    } ttfu_op_e;

    function automatic int unsigned clog2_min1(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ttfu_sock_match.sv
// Input socket: finds the lowest-numbered bus carrying this socket's ID
// and returns that bus's payload.
module ttfu_sock_match #(
    parameter int NUM_BUS = 2,
    parameter int SID_W   = 4,
    parameter int PW      = 8,
    parameter logic [SID_W-1:0] SID = '0
) (
    input  logic [NUM_BUS*SID_W-1:0] sid_flat,
    input  logic [NUM_BUS*PW-1:0]    pay_flat,
    output logic                     hit,
    output logic [PW-1:0]            pay
);
    always_comb begin
        hit = 1'b0;
        pay = '0;
        // scan downwards so the lowest index is the last to win
        for (int b = NUM_BUS - 1; b >= 0; b--) begin
            if (sid_flat[b*SID_W +: SID_W] == SID) begin
                hit = 1'b1;
                pay = pay_flat[b*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/ttfu_alu.sv
module ttfu_alu
    import ttfu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [OP_W-1:0] op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   y
);
    always_comb begin
        y = '0;
        case (ttfu_op_e'(op))
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_CMP:  y[0] = (a < b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/ttfu_pipe.sv
// Result pipeline: one stage (latency 1) or two stages (latency 2).
module ttfu_pipe #(
    parameter int DW      = 8,
    parameter int LATENCY = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [DW-1:0] in_data,
    output logic [DW-1:0] res_q
);
    generate
        if (LATENCY == 1) begin : g_lat1
            always_ff @(posedge clk) begin
                if (rst)         res_q <= '0;
                else if (in_vld) res_q <= in_data;
            end
        end else begin : g_lat2
            typedef struct packed {
                logic          vld;
                logic [DW-1:0] data;
            } stage_t;

            stage_t stg_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    stg_q <= '0;
                    res_q <= '0;
                end else begin
                    stg_q <= '{vld: in_vld, data: in_data};
                    if (stg_q.vld) res_q <= stg_q.data;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ttfu_out_socket.sv
// Output socket: drives the result onto every addressed bus and flags clashes.
module ttfu_out_socket #(
    parameter int NUM_BUS = 2,
    parameter int SID_W   = 4,
    parameter int DW      = 8,
    parameter logic [SID_W-1:0] SID = '0
) (
    input  logic [NUM_BUS*SID_W-1:0] sid_flat,
    input  logic [DW-1:0]            result,
    input  logic [NUM_BUS-1:0]       ext_drv,
    output logic [NUM_BUS*DW-1:0]    data_o,
    output logic [NUM_BUS-1:0]       drv_o,
    output logic [NUM_BUS-1:0]       conflict_o
);
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        assign drv_o[b]              = (sid_flat[b*SID_W +: SID_W] == SID);
        assign data_o[b*DW +: DW]    = drv_o[b] ? result : '0;
        assign conflict_o[b]         = drv_o[b] & ext_drv[b];
    end
endmodule

// File: rtl/ttfu_socket_unit.sv
module ttfu_socket_unit
    import ttfu_pkg::*;
#(
    parameter int NUM_BUS  = 2,
    parameter int DW       = 8,
    parameter int SID_W    = 4,
    parameter int LATENCY  = 2,
    parameter logic [SID_W-1:0] OPND_SID = 4'd1,
    parameter logic [SID_W-1:0] TRIG_SID = 4'd2,
    parameter logic [SID_W-1:0] RES_SID  = 4'd3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_BUS*SID_W-1:0] bus_sid_i,
    input  logic [NUM_BUS*DW-1:0]    bus_data_i,
    input  logic [NUM_BUS*OP_W-1:0]  bus_op_i,
    input  logic [NUM_BUS-1:0]       ext_drv_i,
    output logic [NUM_BUS*DW-1:0]    bus_data_o,
    output logic [NUM_BUS-1:0]       bus_drv_o,
    output logic [NUM_BUS-1:0]       conflict_o
);
    localparam int TPW = OP_W + DW;

    typedef struct packed {
        logic [OP_W-1:0] op;
        logic [DW-1:0]   data;
    } trig_t;

    logic [NUM_BUS*TPW-1:0] trig_flat;
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_tpay
        assign trig_flat[b*TPW +: TPW] = {bus_op_i[b*OP_W +: OP_W], bus_data_i[b*DW +: DW]};
    end

    logic          opnd_hit;
    logic [DW-1:0] opnd_mv;
    logic          trig_hit;
    trig_t         trig_mv;
    logic [DW-1:0] opnd_q;
    logic [DW-1:0] opnd_eff;
    logic [DW-1:0] alu_y;
    logic [DW-1:0] result_q;

    ttfu_sock_match #(.NUM_BUS(NUM_BUS), .SID_W(SID_W), .PW(DW), .SID(OPND_SID)) u_opnd_sock (
        .sid_flat (bus_sid_i),
        .pay_flat (bus_data_i),
        .hit      (opnd_hit),
        .pay      (opnd_mv)
    );

    ttfu_sock_match #(.NUM_BUS(NUM_BUS), .SID_W(SID_W), .PW(TPW), .SID(TRIG_SID)) u_trig_sock (
        .sid_flat (bus_sid_i),
        .pay_flat (trig_flat),
        .hit      (trig_hit),
        .pay      (trig_mv)
    );

    always_ff @(posedge clk) begin
        if (rst)           opnd_q <= '0;
        else if (opnd_hit) opnd_q <= opnd_mv;
    end

    // a same-cycle operand move is forwarded into the triggered operation
    assign opnd_eff = opnd_hit ? opnd_mv : opnd_q;

    ttfu_alu #(.DW(DW)) u_alu (
        .op (trig_mv.op),
        .a  (opnd_eff),
        .b  (trig_mv.data),
        .y  (alu_y)
    );

    ttfu_pipe #(.DW(DW), .LATENCY(LATENCY)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (trig_hit),
        .in_data (alu_y),
        .res_q   (result_q)
    );

    ttfu_out_socket #(.NUM_BUS(NUM_BUS), .SID_W(SID_W), .DW(DW), .SID(RES_SID)) u_res_sock (
        .sid_flat   (bus_sid_i),
        .result     (result_q),
        .ext_drv    (ext_drv_i),
        .data_o     (bus_data_o),
        .drv_o      (bus_drv_o),
        .conflict_o (conflict_o)
    );
endmodule

// File: rtl/ttfu_socket_unit_chk.sv
module ttfu_socket_unit_chk #(
    parameter int NUM_BUS = 2,
    parameter int DW      = 8,
    parameter int SID_W   = 4,
    parameter int LATENCY = 2,
    parameter logic [SID_W-1:0] TRIG_SID = 4'd2,
    parameter logic [SID_W-1:0] RES_SID  = 4'd3
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_BUS*SID_W-1:0] bus_sid_i,
    input logic [NUM_BUS-1:0]       ext_drv_i,
    input logic [NUM_BUS*DW-1:0]    bus_data_o,
    input logic [NUM_BUS-1:0]       bus_drv_o,
    input logic [NUM_BUS-1:0]       conflict_o,
    input logic [DW-1:0]            result_q
);
    logic trig_seen;
    always_comb begin
        trig_seen = 1'b0;
        for (int b = 0; b < NUM_BUS; b++)
            if (bus_sid_i[b*SID_W +: SID_W] == TRIG_SID) trig_seen = 1'b1;
    end

    // R1: the result register is cleared by reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (result_q == '0));

    // R2, R4: without a trigger LATENCY cycles earlier the result holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(trig_seen, LATENCY) |-> $stable(result_q));

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        // R8: a bus is driven only when it addresses the result socket
        p_drive_id_r8: assert property (@(posedge clk) disable iff (rst)
            bus_drv_o[b] |-> (bus_sid_i[b*SID_W +: SID_W] == RES_SID));

        // R8: a driven bus carries the result, an undriven one carries 0
        p_drive_val_r8: assert property (@(posedge clk) disable iff (rst)
            bus_drv_o[b] |-> (bus_data_o[b*DW +: DW] == result_q));

        p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
            !bus_drv_o[b] |-> (bus_data_o[b*DW +: DW] == '0));

        // R9: conflict exactly when two drivers are enabled
        p_conflict_set_r9: assert property (@(posedge clk) disable iff (rst)
            (bus_drv_o[b] && ext_drv_i[b]) |-> conflict_o[b]);

        p_conflict_only_r9: assert property (@(posedge clk) disable iff (rst)
            conflict_o[b] |-> (bus_drv_o[b] && ext_drv_i[b]));
    end
endmodule

bind ttfu_socket_unit ttfu_socket_unit_chk #(
    .NUM_BUS  (NUM_BUS),
    .DW       (DW),
    .SID_W    (SID_W),
    .LATENCY  (LATENCY),
    .TRIG_SID (TRIG_SID),
    .RES_SID  (RES_SID)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sid_i  (bus_sid_i),
    .ext_drv_i  (ext_drv_i),
    .bus_data_o (bus_data_o),
    .bus_drv_o  (bus_drv_o),
    .conflict_o (conflict_o),
    .result_q   (result_q)
);

// File: tb/ttfu_socket_unit_bench.sv
`timescale 1ns/1ps
module ttfu_socket_unit_bench;
    localparam int NB  = 2;
    localparam int DW  = 8;
    localparam int SW  = 4;
    localparam int LAT = 2;
    localparam logic [SW-1:0] S_IDLE = 4'd0;
    localparam logic [SW-1:0] S_OPND = 4'd1;
    localparam logic [SW-1:0] S_TRIG = 4'd2;
    localparam logic [SW-1:0] S_RES  = 4'd3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NB*SW-1:0]  sid;
    logic [NB*DW-1:0]  din;
    logic [NB*3-1:0]   opc;
    logic [NB-1:0]     ext;
    logic [NB*DW-1:0]  dout;
    logic [NB-1:0]     drv;
    logic [NB-1:0]     cfl;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ttfu_socket_unit #(.NUM_BUS(NB), .DW(DW), .SID_W(SW), .LATENCY(LAT)) u_ttfu_socket_unit (
        .clk        (clk),
        .rst        (rst),
        .bus_sid_i  (sid),
        .bus_data_i (din),
        .bus_op_i   (opc),
        .ext_drv_i  (ext),
        .bus_data_o (dout),
        .bus_drv_o  (drv),
        .conflict_o (cfl)
    );

    function automatic logic [DW-1:0] ref_op(input int op, input int a, input int b);
        case (op)
            0: return DW'((a + b) % 256);
            1: return DW'((a - b + 256) % 256);
            2: return DW'(a & b);
            3: return DW'(a | b);
            4: return DW'(a ^ b);
            5: return (a < b) ? DW'(1) : DW'(0);
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear();
        sid = '0; din = '0; opc = '0; ext = '0;
    endtask

    // start a new cycle with every bus idle
    task automatic cyc();
        @(negedge clk);
        clear();
    endtask

    task automatic put(input int b, input logic [SW-1:0] s, input int d, input int o);
        sid[b*SW +: SW] = s;
        din[b*DW +: DW] = DW'(d);
        opc[b*3 +: 3]   = 3'(o);
    endtask

    function automatic int bus_val(input int b);
        return int'(dout[b*DW +: DW]);
    endfunction

    // read result on bus 0 in the current cycle and compare
    task automatic read_chk(input string req, input int exp);
        put(0, S_RES, 0, 0);
        #1;
        chk(req, bus_val(0), exp);
    endtask

    // operand move, trigger move, wait, read
    task automatic run_op(input string req, input int a, input int b, input int op);
        cyc(); put(0, S_OPND, a, 0);
        cyc(); put(1, S_TRIG, b, op);
        for (int i = 0; i < LAT - 1; i++) cyc();
        cyc(); read_chk(req, int'(ref_op(op, a, b)));
    endtask

    initial begin
        int vals [6] = '{0, 1, 127, 128, 254, 255};
        int prev;
        clear();
        repeat (3) @(posedge clk);
        // R1: in reset nothing is driven
        #1 chk("R1 drv in reset", int'(drv), 0);
        @(negedge clk); rst = 1'b0;
        #1 chk("R1 drv after reset", int'(drv), 0);
        cyc(); read_chk("R1 result after reset", 0);
        chk("R1 drv when read", int'(drv), 1);

        // R3: sweep of opcodes over corner operands
        for (int op = 0; op < 8; op++)
            for (int ia = 0; ia < 6; ia++)
                for (int ib = 0; ib < 6; ib++)
                    run_op("R3 op sweep", vals[ia], vals[ib], op);

        // R4: exact latency and hold of previous result
        run_op("R4 setup", 10, 20, 0);
        prev = 30;
        cyc(); put(0, S_OPND, 7, 0);
        cyc(); put(1, S_TRIG, 5, 1); read_chk("R4 trigger cycle old", prev);
        for (int i = 1; i < LAT; i++) begin
            cyc(); read_chk("R4 before latency old", prev);
        end
        cyc(); read_chk("R4 at latency new", 2);
        cyc(); read_chk("R4 held", 2);

        // R2: operand move alone leaves the result untouched
        cyc(); put(0, S_OPND, 99, 0);
        cyc(); read_chk("R2 after operand move", 2);
        for (int i = 0; i < LAT; i++) cyc();
        read_chk("R2 still held", 2);
        cyc(); put(1, S_TRIG, 1, 0);
        for (int i = 0; i < LAT; i++) cyc();
        read_chk("R2 operand was stored", 100);

        // R6: same-cycle operand and trigger use the new operand
        cyc(); put(0, S_OPND, 5, 0); put(1, S_TRIG, 3, 0);
        for (int i = 0; i < LAT; i++) cyc();
        read_chk("R6 forwarded operand", 8);
        cyc(); put(1, S_TRIG, 1, 0);
        for (int i = 0; i < LAT; i++) cyc();
        read_chk("R6 operand kept", 6);

        // R7: lowest bus wins on duplicate IDs
        cyc(); put(0, S_OPND, 1, 0);
        cyc(); put(0, S_TRIG, 10, 0); put(1, S_TRIG, 20, 1);
        for (int i = 0; i < LAT; i++) cyc();
        read_chk("R7 trigger priority", 11);
        cyc(); put(0, S_OPND, 2, 0); put(1, S_OPND, 9, 0);
        cyc(); put(1, S_TRIG, 0, 3);
        for (int i = 0; i < LAT; i++) cyc();
        read_chk("R7 operand priority", 2);

        // R5: back-to-back triggers, results in order
        cyc(); put(0, S_OPND, 3, 0);
        for (int i = 0; i < 8 + LAT; i++) begin
            cyc();
            if (i < 8) put(1, S_TRIG, i * 7, 0);
            if (i >= LAT) read_chk("R5 pipelined result", 3 + (i - LAT) * 7);
        end

        // R8: both buses read; non-reading bus stays quiet
        cyc(); put(0, S_RES, 0, 0); put(1, S_RES, 0, 0);
        #1;
        chk("R8 dual read bus0", bus_val(0), 52);
        chk("R8 dual read bus1", bus_val(1), 52);
        chk("R8 dual enable", int'(drv), 3);
        cyc(); put(0, S_RES, 0, 0); put(1, S_OPND, 4, 0);
        #1;
        chk("R8 quiet bus data", bus_val(1), 0);
        chk("R8 quiet bus enable", int'(drv), 1);

        // R9: conflict flags
        cyc(); put(0, S_RES, 0, 0); ext = 2'b11;
        #1 chk("R9 conflict only on driven bus", int'(cfl), 1);
        cyc(); ext = 2'b11;
        #1 chk("R9 no conflict without own drive", int'(cfl), 0);
        cyc(); put(1, S_RES, 0, 0);
        #1 chk("R9 no conflict without external", int'(cfl), 0);

        cyc();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule